// File: doc/BRIEF.md
# Micro-TLB Context Routing Table

This block keeps one routing entry per bus-master micro-TLB. Each entry says whether translation is on for that micro-TLB and which of up to eight translation contexts serves it. Software programs the entries through a 32-bit register port. A second, combinational port lets the translation path look up any micro-TLB index in the same cycle it asks.

Each entry has a control register and an address-space identifier register. The control register holds an enable bit, a context selector and a flush request. The flush request is not stored. Writing it raises an invalidate pulse for one cycle, tagged with the micro-TLB index, so that the owning micro-TLB can drop its cached translations. The entry registers sit in two separate address windows. The first 32 indices use one window and the remaining indices use the other.

Top module: `utlb_route_table`

## Requirements
- R1: After reset every entry is disabled, with context 0 and identifier 0. The invalidate pulse is low and the read data is zero.
- R2: For an index n below 32, the control register sits at byte offset 0x300 + 16·n.
- R3: For an index n from 32 to 47, the control register sits at byte offset 0x600 + 16·(n−32).
- R4: In the control register, bit 0 is the enable and bits 6:4 are the context selector. A read returns these two fields and zero in every other bit.
- R5: A control write with bit 1 set drives inv_valid high for exactly the one cycle after the write, with inv_index equal to the entry index. The same write also updates the enable and context fields. Bit 1 always reads back as 0.
- R6: The identifier register of each entry sits 8 bytes above its control register. It stores write bits 7:0, and a read returns them with zero in bits 31:8.
- R7: Writing zero to a control register disables translation for that micro-TLB and sets its context to 0.
- R8: The lookup port is combinational. For an index below 48 it returns the stored enable and context of that entry. For an index of 48 or above it returns disabled and context 0.
- R9: Reads of any offset that is not a control or identifier register return zero. Writes to such offsets change no entry and raise no invalidate pulse. This covers offsets 4 and 12 inside an entry slot, the gap from 0x500 to 0x5FF, and every offset outside both windows.
- R10: reg_rdata takes its new value on the clock edge that samples a read access. It keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lk_index | input | 6 | Micro-TLB index to look up |
| lk_enable | output | 1 | Translation enabled for lk_index |
| lk_ctx | output | 3 | Context selected for lk_index |
| inv_valid | output | 1 | One-cycle invalidate pulse |
| inv_index | output | 6 | Micro-TLB index to invalidate |

## Verification
The assertions assume that reg_en, reg_we and the write data are known values on every clock edge. Under that assumption, an invalidate pulse can only follow a cycle that carried a write with bit 1 set. They also assume that the lookup outputs can move only because lk_index changed or because a write happened in the previous cycle.

The stimulus keeps within these assumptions. It changes inputs only on the falling edge and drops reg_en to zero between accesses. During the steady-state checks it holds lk_index still, so that any change on the lookup outputs must come from a write. The sweeps visit every index through both address windows, every context value, and all out-of-range lookup indices.

// File: rtl/utlb_route_pkg.sv
package utlb_route_pkg;
    localparam int unsigned EN_BIT     = 0;
    localparam int unsigned FLUSH_BIT  = 1;
    localparam int unsigned CTX_LSB    = 4;
    localparam int unsigned ASID_OFF   = 8;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_CTRL = 2'd1,
        KIND_ASID = 2'd2
    } reg_kind_e;
endpackage

// File: rtl/utlb_addr_decode.sv
module utlb_addr_decode
    import utlb_route_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_ENTRIES = 48,
    parameter int unsigned LOW_ENTRIES = 32,
    parameter int unsigned LOW_BASE    = 32'h300,
    parameter int unsigned HIGH_BASE   = 32'h600,
    parameter int unsigned STRIDE      = 16,
    parameter int unsigned IDX_W       = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  index
);
    localparam int unsigned HIGH_ENTRIES = NUM_ENTRIES - LOW_ENTRIES;
    localparam int unsigned STRIDE_SH    = $clog2(STRIDE);
    localparam int unsigned LOW_END      = LOW_BASE + LOW_ENTRIES * STRIDE;
    localparam int unsigned HIGH_END     = HIGH_BASE + HIGH_ENTRIES * STRIDE;

    logic [31:0] addr32;
    logic        lo_hit;
    logic        hi_hit;
    logic [31:0] lo_rel;
    logic [31:0] hi_rel;

    assign addr32 = 32'(addr);
    assign lo_hit = (addr32 >= LOW_BASE) && (addr32 < LOW_END);
    assign lo_rel = addr32 - LOW_BASE;

    generate
        if (HIGH_ENTRIES > 0) begin : g_high
            assign hi_hit = (addr32 >= HIGH_BASE) && (addr32 < HIGH_END);
            assign hi_rel = addr32 - HIGH_BASE;
        end else begin : g_no_high
            assign hi_hit = 1'b0;
            assign hi_rel = '0;
        end
    endgenerate

    always_comb begin
        logic [31:0] rel;
        logic [31:0] slot;
        logic [31:0] off;
        logic        hit;
        kind  = KIND_NONE;
        index = '0;
        hit   = 1'b0;
        rel   = '0;
        slot  = '0;
        if (lo_hit) begin
            hit  = 1'b1;
            rel  = lo_rel;
            slot = lo_rel >> STRIDE_SH;
        end else if (hi_hit) begin
            hit  = 1'b1;
            rel  = hi_rel;
            slot = (hi_rel >> STRIDE_SH) + LOW_ENTRIES;
        end
        off = rel & (STRIDE - 1);
        if (hit) begin
            if (off == 32'd0) begin
                kind  = KIND_CTRL;
                index = IDX_W'(slot);
            end else if (off == ASID_OFF) begin
                kind  = KIND_ASID;
                index = IDX_W'(slot);
            end
        end
    end
endmodule

// File: rtl/utlb_entry_bank.sv
module utlb_entry_bank
    import utlb_route_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 48,
    parameter int unsigned IDX_W       = 6,
    parameter int unsigned CTX_W       = 3,
    parameter int unsigned ASID_W      = 8,
    parameter int unsigned DATA_W      = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_en,
    input  logic                              acc_we,
    input  reg_kind_e                         acc_kind,
    input  logic [IDX_W-1:0]                  acc_index,
    input  logic [DATA_W-1:0]                 acc_wdata,
    output logic [DATA_W-1:0]                 rdata,
    output logic                              inv_valid,
    output logic [IDX_W-1:0]                  inv_index,
    output logic [NUM_ENTRIES-1:0]            en_vec,
    output logic [NUM_ENTRIES-1:0][CTX_W-1:0] ctx_vec
);
    typedef struct packed {
        logic [NUM_ENTRIES-1:0]             en;
        logic [NUM_ENTRIES-1:0][CTX_W-1:0]  ctx;
        logic [NUM_ENTRIES-1:0][ASID_W-1:0] asid;
        logic                               inv_valid;
        logic [IDX_W-1:0]                   inv_index;
        logic [DATA_W-1:0]                  rdata;
    } bank_state_t;

    bank_state_t state_d, state_q;
    logic [DATA_W-1:0] read_val;
    logic              idx_ok;

    assign idx_ok = 32'(acc_index) < NUM_ENTRIES;

    always_comb begin
        read_val = '0;
        if (idx_ok) begin
            case (acc_kind)
                KIND_CTRL: begin
                    read_val[EN_BIT]            = state_q.en[acc_index];
                    read_val[CTX_LSB +: CTX_W]  = state_q.ctx[acc_index];
                end
                KIND_ASID: read_val[ASID_W-1:0] = state_q.asid[acc_index];
                default:   read_val = '0;
            endcase
        end
    end

    always_comb begin
        state_d           = state_q;
        state_d.inv_valid = 1'b0;
        state_d.inv_index = '0;
        if (acc_en && acc_we && idx_ok) begin
            case (acc_kind)
                KIND_CTRL: begin
                    state_d.en[acc_index]  = acc_wdata[EN_BIT];
                    state_d.ctx[acc_index] = acc_wdata[CTX_LSB +: CTX_W];
                    if (acc_wdata[FLUSH_BIT]) begin
                        state_d.inv_valid = 1'b1;
                        state_d.inv_index = acc_index;
                    end
                end
                KIND_ASID: state_d.asid[acc_index] = acc_wdata[ASID_W-1:0];
                default: ;
            endcase
        end
        if (acc_en && !acc_we) begin
            state_d.rdata = read_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata     = state_q.rdata;
    assign inv_valid = state_q.inv_valid;
    assign inv_index = state_q.inv_index;
    assign en_vec    = state_q.en;
    assign ctx_vec   = state_q.ctx;
endmodule

// File: rtl/utlb_lookup.sv
module utlb_lookup #(
    parameter int unsigned NUM_ENTRIES = 48,
    parameter int unsigned IDX_W       = 6,
    parameter int unsigned CTX_W       = 3
) (
    input  logic [NUM_ENTRIES-1:0]            en_vec,
    input  logic [NUM_ENTRIES-1:0][CTX_W-1:0] ctx_vec,
    input  logic [IDX_W-1:0]                  index,
    output logic                              enable,
    output logic [CTX_W-1:0]                  ctx
);
    always_comb begin
        enable = 1'b0;
        ctx    = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (32'(index) == i) begin
                enable = en_vec[i];
                ctx    = ctx_vec[i];
            end
        end
    end
endmodule

// File: rtl/utlb_route_table.sv
module utlb_route_table
    import utlb_route_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 48,
    parameter int unsigned LOW_ENTRIES = 32,
    parameter int unsigned NUM_CTX     = 8,
    parameter int unsigned ASID_W      = 8,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned LOW_BASE    = 32'h300,
    parameter int unsigned HIGH_BASE   = 32'h600,
    parameter int unsigned STRIDE      = 16,
    localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
    localparam int unsigned CTX_W      = $clog2(NUM_CTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [IDX_W-1:0]  lk_index,
    output logic              lk_enable,
    output logic [CTX_W-1:0]  lk_ctx,
    output logic              inv_valid,
    output logic [IDX_W-1:0]  inv_index
);
    reg_kind_e                         dec_kind;
    logic [IDX_W-1:0]                  dec_index;
    logic [NUM_ENTRIES-1:0]            en_vec;
    logic [NUM_ENTRIES-1:0][CTX_W-1:0] ctx_vec;

    utlb_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .LOW_ENTRIES(LOW_ENTRIES),
        .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE), .STRIDE(STRIDE), .IDX_W(IDX_W)
    ) u_decode (
        .addr (reg_addr),
        .kind (dec_kind),
        .index(dec_index)
    );

    utlb_entry_bank #(
        .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .CTX_W(CTX_W),
        .ASID_W(ASID_W), .DATA_W(DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (reg_en),
        .acc_we   (reg_we),
        .acc_kind (dec_kind),
        .acc_index(dec_index),
        .acc_wdata(reg_wdata),
        .rdata    (reg_rdata),
        .inv_valid(inv_valid),
        .inv_index(inv_index),
        .en_vec   (en_vec),
        .ctx_vec  (ctx_vec)
    );

    utlb_lookup #(
        .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .CTX_W(CTX_W)
    ) u_lookup (
        .en_vec (en_vec),
        .ctx_vec(ctx_vec),
        .index  (lk_index),
        .enable (lk_enable),
        .ctx    (lk_ctx)
    );
endmodule

// File: rtl/utlb_route_table_chk.sv
module utlb_route_table_chk #(
    parameter int unsigned NUM_ENTRIES = 48,
    parameter int unsigned IDX_W       = 6,
    parameter int unsigned CTX_W       = 3,
    parameter int unsigned DATA_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [IDX_W-1:0]  lk_index,
    input logic              lk_enable,
    input logic [CTX_W-1:0]  lk_ctx,
    input logic              inv_valid,
    input logic [IDX_W-1:0]  inv_index
);
    // R5
    inv_from_flush_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(reg_en && reg_we && reg_wdata[1]));

    // R5
    inv_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (32'(inv_index) < NUM_ENTRIES));

    // R8
    lookup_out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(lk_index) >= NUM_ENTRIES) |-> (!lk_enable && lk_ctx == '0));

    // R8
    lookup_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_en && reg_we) && $stable(lk_index)) |-> ($stable(lk_enable) && $stable(lk_ctx)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_en && !reg_we) |-> $stable(reg_rdata));
endmodule

bind utlb_route_table utlb_route_table_chk #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .CTX_W(CTX_W), .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_en   (reg_en),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .lk_index (lk_index),
    .lk_enable(lk_enable),
    .lk_ctx   (lk_ctx),
    .inv_valid(inv_valid),
    .inv_index(inv_index)
);

// File: tb/utlb_route_table_test.sv
module utlb_route_table_test;
    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  lk_index = '0;
    logic        lk_enable;
    logic [2:0]  lk_ctx;
    logic        inv_valid;
    logic [5:0]  inv_index;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit       exp_en   [N];
    bit [2:0] exp_ctx  [N];
    bit [7:0] exp_asid [N];

    always #4 clk = ~clk;

    utlb_route_table uut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_index(lk_index), .lk_enable(lk_enable), .lk_ctx(lk_ctx),
        .inv_valid(inv_valid), .inv_index(inv_index)
    );

    function automatic logic [11:0] ctrl_addr(int n);
        return (n < 32) ? 12'(32'h300 + 16 * n) : 12'(32'h600 + 16 * (n - 32));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic check_all_lookups(string req);
        for (int i = 0; i < 64; i++) begin
            lk_index = 6'(i);
            #1;
            if (i < N) begin
                check(req, {31'd0, lk_enable}, {31'd0, exp_en[i]});
                check(req, {29'd0, lk_ctx}, {29'd0, exp_ctx[i]});
            end else begin
                check(req, {28'd0, lk_enable, lk_ctx}, 32'd0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < N; i++) begin
            exp_en[i] = 0; exp_ctx[i] = 0; exp_asid[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {31'd0, inv_valid}, 32'd0);
        check("R1", reg_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all_lookups("R1");
        for (int i = 0; i < N; i++) begin
            rd(ctrl_addr(i) + 12'd8, r);
            check("R1", r, 32'd0);
        end

        // R2 R3 R4 R6: program every entry in both windows
        for (int i = 0; i < N; i++) begin
            exp_en[i]   = ((i % 3) != 0);
            exp_ctx[i]  = 3'(i % 8);
            exp_asid[i] = 8'(i * 5 + 1);
            wr(ctrl_addr(i), 32'hFFFF_FF00 | (32'(exp_ctx[i]) << 4) | 32'(exp_en[i]));
            wr(ctrl_addr(i) + 12'd8, 32'hABCD_0000 | 32'(exp_asid[i]));
        end
        check_all_lookups("R2_R3_R8");
        for (int i = 0; i < N; i++) begin
            rd(ctrl_addr(i), r);
            check(i < 32 ? "R2_R4" : "R3_R4", r, (32'(exp_ctx[i]) << 4) | 32'(exp_en[i]));
            rd(ctrl_addr(i) + 12'd8, r);
            check("R6", r, 32'(exp_asid[i]));
        end

        // R10: read data holds with no read
        lk_index = 6'd5;
        repeat (3) @(negedge clk);
        check("R10", reg_rdata, 32'(exp_asid[N-1]));

        // R5: flush pulse for a sample of entries in both windows
        for (int k = 0; k < 6; k++) begin
            int i;
            i = (k * 9 + 2) % N;
            exp_en[i] = 1; exp_ctx[i] = 3'(7 - k);
            @(negedge clk);
            reg_en = 1'b1; reg_we = 1'b1; reg_addr = ctrl_addr(i);
            reg_wdata = 32'h3 | (32'(exp_ctx[i]) << 4);
            @(negedge clk);
            reg_en = 1'b0; reg_we = 1'b0;
            check("R5", {31'd0, inv_valid}, 32'd1);
            check("R5", {26'd0, inv_index}, 32'(i));
            @(negedge clk);
            check("R5", {31'd0, inv_valid}, 32'd0);
            rd(ctrl_addr(i), r);
            check("R5", r, (32'(exp_ctx[i]) << 4) | 32'd1);
        end

        // R7: writing zero disables
        for (int i = 0; i < N; i += 7) begin
            wr(ctrl_addr(i), 32'd0);
            exp_en[i] = 0; exp_ctx[i] = 0;
        end
        check_all_lookups("R7");

        // R9: gaps and holes ignored, read zero
        for (int a = 0; a < 4096; a += 4) begin
            int rel;
            bit is_reg;
            is_reg = 0;
            if (a >= 32'h300 && a < 32'h500) begin
                rel = (a - 32'h300) % 16;
                is_reg = (rel == 0) || (rel == 8);
            end else if (a >= 32'h600 && a < 32'h700) begin
                rel = (a - 32'h600) % 16;
                is_reg = (rel == 0) || (rel == 8);
            end
            if (!is_reg && (a % 64 == 4 || a % 64 == 12 || a < 32'h300 || a >= 32'h700 ||
                            (a >= 32'h500 && a < 32'h600))) begin
                @(negedge clk);
                reg_en = 1'b1; reg_we = 1'b1; reg_addr = 12'(a); reg_wdata = 32'hFFFF_FFFF;
                @(negedge clk);
                reg_en = 1'b0; reg_we = 1'b0;
                if (inv_valid !== 1'b0) check("R9", {31'd0, inv_valid}, 32'd0);
                if (a % 256 == 4) begin
                    rd(12'(a), r);
                    check("R9", r, 32'd0);
                end
            end
        end
        check_all_lookups("R9");
        for (int i = 0; i < N; i += 5) begin
            rd(ctrl_addr(i) + 12'd8, r);
            check("R9", r, 32'(exp_asid[i]));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule